// File: doc/BRIEF.md
# SCL Clock Generator

This block derives the serial clock of a two-wire bus master from the system clock. Each half of an SCL period lasts `(THP+1) * 2^N * (M+1) * 10` system cycles. The three factors come from three chained counter stages. A half-period counter compares against THP, a power-of-two prescaler counts `2^N` of those ticks, and a decade stage counts `(M+1)*10` prescaled ticks. The resulting SCL frequency is `f_sys / (2*(THP+1)) / 2^N / (M+1) / 10`. Software picks the three values and writes them with a one-cycle load strobe. THP arrives on an 8-bit bus. M and N share one 7-bit control word.

The generator drives a registered SCL level and three strobes for the byte engine:
- a rising-edge strobe,
- a falling-edge strobe,
- a sampling tick in the middle of each high phase.

Newly loaded divisors wait in a pending copy. The running copy picks them up only at the start of a period, so a period never mixes two settings. A stretch input lets a slave that holds SCL low delay the next rising edge. When the slave lets go, the high phase starts fresh.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset, SCL is high and every strobe is low. The divisors default to THP=24, M=2, N=0, so each half period lasts 750 cycles.
- R2: While enabled and not stretched, the high phase and the low phase each last H = (THP+1) * 2^N * (M+1) * 10 system cycles.
- R3: The control word carries M in bits 6:3 and N in bits 2:0. THP is a separate 8-bit value, so M spans 0..15, N spans 0..7 and THP spans up to 255.
- R4: A THP value below 5 is stored as 5.
- R5: A load while SCL is running leaves the period in progress unchanged, and the new values govern the period that starts at the next rising edge. A load while disabled takes effect when the block is enabled.
- R6: `sample_tick` pulses for one cycle, exactly H/2 cycles after the rising-edge strobe, while SCL is high.
- R7: `scl_rise` and `scl_fall` are single-cycle pulses in the first cycle of the new SCL level. They are never asserted together, and never together with `sample_tick`.
- R8: If `stretch` is high when a low phase ends, SCL stays low. SCL rises in the cycle after `stretch` is first seen low, and the high phase that follows lasts a full H. `stretch` has no effect during a high phase, or when it is released before the low phase ends.
- R9: With `en` low, SCL is held high and no strobe is produced. When `en` goes high, a high phase starts with cleared counters, and the first falling strobe comes H cycles after the enabling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the divider; low parks SCL high |
| cfg_load | input | 1 | One-cycle strobe that captures `cfg_thp` and `cfg_div` into the pending copy |
| cfg_thp | input | 8 | Half-period base count THP |
| cfg_div | input | 7 | M in bits 6:3, N in bits 2:0 |
| stretch | input | 1 | A slave is holding SCL low |
| scl_o | output | 1 | Registered SCL level |
| scl_rise | output | 1 | Pulse in the first high cycle of each period |
| scl_fall | output | 1 | Pulse in the first low cycle |
| sample_tick | output | 1 | Pulse in the middle of the high phase |

## Verification
The bench builds the block with its default parameters: an 8-bit THP, a 4-bit M, a 3-bit N and a decade factor of 10. The real register widths are therefore exercised, including the 0x18/2/0 reset setting and THP=255. Keeping THP near its floor and N and M small gives half periods of tens to hundreds of cycles. That puts a mid-period reload, stretch release timing, the THP clamp and randomly drawn settings within reach of exact cycle-count checks.

// File: rtl/scl_clk_pkg.sv
package scl_clk_pkg;

  // Phase of the generated serial clock.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // disabled, SCL parked high
    PH_HIGH = 2'd1,  // counting the high half period
    PH_LOW  = 2'd2,  // counting the low half period
    PH_HOLD = 2'd3   // low phase expired, waiting for the slave to release
  } scl_phase_e;

  localparam int SCL_THP_FLOOR = 5;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int THP_W   = 8,
  parameter int M_W     = 4,
  parameter int N_W     = 3,
  parameter int THP_MIN = 5,
  parameter int THP_RST = 24,
  parameter int M_RST   = 2,
  parameter int N_RST   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             commit,
  input  logic [THP_W-1:0] thp_in,
  input  logic [M_W+N_W-1:0] div_in,
  output logic [THP_W-1:0] thp_act,
  output logic [M_W-1:0]   m_act,
  output logic [N_W-1:0]   n_act
);

  localparam logic [THP_W-1:0] THP_MIN_V = THP_MIN[THP_W-1:0];
  localparam logic [THP_W-1:0] THP_RST_V = THP_RST[THP_W-1:0];
  localparam logic [M_W-1:0]   M_RST_V   = M_RST[M_W-1:0];
  localparam logic [N_W-1:0]   N_RST_V   = N_RST[N_W-1:0];

  logic [THP_W-1:0] thp_pend_q, thp_pend_d, thp_act_q, thp_act_d;
  logic [M_W-1:0]   m_pend_q, m_pend_d, m_act_q, m_act_d;
  logic [N_W-1:0]   n_pend_q, n_pend_d, n_act_q, n_act_d;
  logic [THP_W-1:0] thp_clamped;

  // Raise values below the supported floor.
  always_comb begin
    thp_clamped = (thp_in < THP_MIN_V) ? THP_MIN_V : thp_in;
  end

  always_comb begin
    thp_pend_d = thp_pend_q;
    m_pend_d   = m_pend_q;
    n_pend_d   = n_pend_q;
    if (load) begin
      thp_pend_d = thp_clamped;
      m_pend_d   = div_in[M_W+N_W-1:N_W];
      n_pend_d   = div_in[N_W-1:0];
    end
  end

  always_comb begin
    thp_act_d = thp_act_q;
    m_act_d   = m_act_q;
    n_act_d   = n_act_q;
    if (commit) begin
      thp_act_d = thp_pend_q;
      m_act_d   = m_pend_q;
      n_act_d   = n_pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thp_pend_q <= THP_RST_V;
      m_pend_q   <= M_RST_V;
      n_pend_q   <= N_RST_V;
      thp_act_q  <= THP_RST_V;
      m_act_q    <= M_RST_V;
      n_act_q    <= N_RST_V;
    end else begin
      thp_pend_q <= thp_pend_d;
      m_pend_q   <= m_pend_d;
      n_pend_q   <= n_pend_d;
      thp_act_q  <= thp_act_d;
      m_act_q    <= m_act_d;
      n_act_q    <= n_act_d;
    end
  end

  assign thp_act = thp_act_q;
  assign m_act   = m_act_q;
  assign n_act   = n_act_q;

endmodule

// File: rtl/scl_div_chain.sv
module scl_div_chain #(
  parameter int THP_W  = 8,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int DECADE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [THP_W-1:0] thp,
  input  logic [M_W-1:0]   m,
  input  logic [N_W-1:0]   n,
  output logic             half_done,
  output logic             mid_done
);

  // Prescale count kept as a binary number whose last value is 2^n-1.
  localparam int PRE_W   = (1 << N_W) - 1;
  localparam int DEC_MAX = (1 << M_W) * DECADE;
  localparam int DEC_W   = $clog2(DEC_MAX);
  localparam int DEC_CW  = DEC_W + 1;

  logic [THP_W-1:0]  base_q, base_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DEC_W-1:0]  dec_q, dec_d;
  logic [PRE_W-1:0]  pre_last;
  logic [DEC_CW-1:0] dec_last, dec_mid;
  logic              base_wrap, pre_wrap, dec_wrap;

  // 2^n - 1 is n low ones: one comparator per prescaler bit.
  for (genvar g = 0; g < PRE_W; g++) begin : g_pre_last
    assign pre_last[g] = (g < int'(n));
  end

  always_comb begin
    dec_last = DEC_CW'((int'(m) + 1) * DECADE - 1);
    dec_mid  = DEC_CW'((int'(m) + 1) * (DECADE / 2) - 1);
  end

  always_comb begin
    base_wrap = (base_q == thp);
    pre_wrap  = base_wrap && (pre_q == pre_last);
    dec_wrap  = pre_wrap && ({1'b0, dec_q} == dec_last);
  end

  always_comb begin
    base_d = base_q;
    pre_d  = pre_q;
    dec_d  = dec_q;
    if (clear) begin
      base_d = '0;
      pre_d  = '0;
      dec_d  = '0;
    end else if (run) begin
      base_d = base_wrap ? '0 : base_q + 1'b1;
      if (base_wrap) begin
        pre_d = pre_wrap ? '0 : pre_q + 1'b1;
      end
      if (pre_wrap) begin
        dec_d = dec_wrap ? '0 : dec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pre_q  <= '0;
      dec_q  <= '0;
    end else begin
      base_q <= base_d;
      pre_q  <= pre_d;
      dec_q  <= dec_d;
    end
  end

  assign half_done = dec_wrap;
  assign mid_done  = pre_wrap && ({1'b0, dec_q} == dec_mid);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_clk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stretch,
  input  logic half_done,
  input  logic mid_done,
  output logic run,
  output logic clear,
  output logic commit,
  output logic scl_o,
  output logic rise_o,
  output logic fall_o,
  output logic sample_o
);

  scl_phase_e ph_q, ph_d;
  logic scl_q, scl_d, rise_q, rise_d, fall_q, fall_d, samp_q, samp_d;

  always_comb begin
    ph_d   = ph_q;
    scl_d  = scl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    samp_d = 1'b0;
    run    = 1'b0;
    clear  = 1'b0;
    commit = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        clear  = 1'b1;
        commit = 1'b1;
        scl_d  = 1'b1;
        if (en) ph_d = PH_HIGH;
      end
      PH_HIGH: begin
        run = 1'b1;
        if (!en) begin
          ph_d  = PH_IDLE;
          scl_d = 1'b1;
          clear = 1'b1;
        end else if (half_done) begin
          ph_d   = PH_LOW;
          scl_d  = 1'b0;
          fall_d = 1'b1;
        end else if (mid_done) begin
          samp_d = 1'b1;
        end
      end
      PH_LOW: begin
        run = 1'b1;
        if (!en) begin
          ph_d  = PH_IDLE;
          scl_d = 1'b1;
          clear = 1'b1;
        end else if (half_done) begin
          clear = 1'b1;
          if (stretch) begin
            ph_d = PH_HOLD;
          end else begin
            ph_d   = PH_HIGH;
            scl_d  = 1'b1;
            rise_d = 1'b1;
            commit = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        clear = 1'b1;
        if (!en) begin
          ph_d  = PH_IDLE;
          scl_d = 1'b1;
        end else if (!stretch) begin
          ph_d   = PH_HIGH;
          scl_d  = 1'b1;
          rise_d = 1'b1;
          commit = 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        scl_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      scl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      scl_q  <= scl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      samp_q <= samp_d;
    end
  end

  assign scl_o    = scl_q;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign sample_o = samp_q;

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
  parameter int THP_W  = 8,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int DECADE = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 cfg_load,
  input  logic [THP_W-1:0]     cfg_thp,
  input  logic [M_W+N_W-1:0]   cfg_div,
  input  logic                 stretch,
  output logic                 scl_o,
  output logic                 scl_rise,
  output logic                 scl_fall,
  output logic                 sample_tick
);

  logic [THP_W-1:0] thp_act;
  logic [M_W-1:0]   m_act;
  logic [N_W-1:0]   n_act;
  logic run, clear, commit, half_done, mid_done;

  scl_cfg_regs #(
    .THP_W  (THP_W),
    .M_W    (M_W),
    .N_W    (N_W),
    .THP_MIN(scl_clk_pkg::SCL_THP_FLOOR),
    .THP_RST(24),
    .M_RST  (2),
    .N_RST  (0)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .commit (commit),
    .thp_in (cfg_thp),
    .div_in (cfg_div),
    .thp_act(thp_act),
    .m_act  (m_act),
    .n_act  (n_act)
  );

  scl_div_chain #(
    .THP_W (THP_W),
    .M_W   (M_W),
    .N_W   (N_W),
    .DECADE(DECADE)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clear    (clear),
    .thp      (thp_act),
    .m        (m_act),
    .n        (n_act),
    .half_done(half_done),
    .mid_done (mid_done)
  );

  scl_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .stretch  (stretch),
    .half_done(half_done),
    .mid_done (mid_done),
    .run      (run),
    .clear    (clear),
    .commit   (commit),
    .scl_o    (scl_o),
    .rise_o   (scl_rise),
    .fall_o   (scl_fall),
    .sample_o (sample_tick)
  );

endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic stretch,
  input logic scl_o,
  input logic scl_rise,
  input logic scl_fall,
  input logic sample_tick
);

  // R7: the rising strobe marks the first high cycle after a low one.
  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_o && !$past(scl_o)));

  // R7: the falling strobe marks the first low cycle after a high one.
  assert_fall_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl_o && $past(scl_o)));

  // R7: at most one strobe at a time.
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, sample_tick}));

  // R6: the sampling tick falls inside a high phase.
  assert_sample_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> scl_o);

  // R9: disabling parks SCL high and silences the strobes.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !scl_rise && !scl_fall && !sample_tick));

  // R8: no rising edge while a slave holds the line.
  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !scl_o && stretch) |=> !scl_rise);

endmodule

bind scl_clk_gen scl_clk_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .stretch    (stretch),
  .scl_o      (scl_o),
  .scl_rise   (scl_rise),
  .scl_fall   (scl_fall),
  .sample_tick(sample_tick)
);

// File: tb/sim_scl_clk_gen.sv
`timescale 1ns/1ps
module sim_scl_clk_gen;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       cfg_load;
  logic [7:0] cfg_thp;
  logic [6:0] cfg_div;
  logic       stretch;
  logic       scl_o, scl_rise, scl_fall, sample_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  scl_clk_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cfg_load   (cfg_load),
    .cfg_thp    (cfg_thp),
    .cfg_div    (cfg_div),
    .stretch    (stretch),
    .scl_o      (scl_o),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sample_tick(sample_tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic int half_len(input int thp, input int m, input int n);
    int t;
    t = (thp < 5) ? 5 : thp;
    return (t + 1) * (1 << n) * (m + 1) * 10;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int thp, input int m, input int n);
    @(negedge clk);
    cfg_thp  = thp[7:0];
    cfg_div  = {m[3:0], n[2:0]};
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!scl_rise) @(negedge clk);
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (!scl_fall) @(negedge clk);
  endtask

  // Called on the cycle a rising strobe is visible.
  task automatic measure_from_rise(output int hi, output int lo, output int samp, output int nsamp);
    int k;
    k = 0; samp = -1; nsamp = 0;
    do begin
      @(negedge clk); k++;
      if (sample_tick) begin samp = k; nsamp++; end
    end while (!scl_fall);
    hi = k;
    k = 0;
    do begin @(negedge clk); k++; end while (!scl_rise);
    lo = k;
  endtask

  task automatic period_check(input string tag, input int h);
    int hi, lo, samp, nsamp;
    wait_rise();
    measure_from_rise(hi, lo, samp, nsamp);
    check_eq({tag, " high"}, hi, h);
    check_eq({tag, " low"}, lo, h);
    check_eq("R6 sample offset", samp, h / 2);
    check_eq("R6 sample count", nsamp, 1);
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k, bad, hi, lo, samp, nsamp;
    rst_n = 1'b0; en = 1'b0; cfg_load = 1'b0; cfg_thp = '0; cfg_div = '0; stretch = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_eq("R1 reset level/strobes", {scl_o, scl_rise, scl_fall, sample_tick}, 4'b1000);

    // R9 + R1: enable with default divisors, first fall H cycles after enabling edge
    en = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!scl_fall);
    check_eq("R9 first fall after enable (R1 defaults)", k, half_len(24, 2, 0) + 1);
    period_check("R1 R2 default", half_len(24, 2, 0));

    // R3: directed settings
    load_cfg(5, 0, 0);
    wait_rise();
    period_check("R2 R3 thp5", half_len(5, 0, 0));
    load_cfg(5, 1, 3);
    wait_rise();
    period_check("R3 m1 n3", half_len(5, 1, 3));
    load_cfg(255, 0, 0);
    wait_rise();
    period_check("R3 thp255", half_len(255, 0, 0));

    // R4: THP below the floor
    load_cfg(2, 0, 0);
    wait_rise();
    period_check("R4 thp clamp", half_len(5, 0, 0));

    // R5: reload in the middle of a high phase
    wait_rise();
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 5) begin cfg_thp = 8'd7; cfg_div = 7'd0; cfg_load = 1'b1; end
      if (k == 6) cfg_load = 1'b0;
    end while (!scl_fall);
    check_eq("R5 current high unchanged", k, 60);
    k = 0;
    do begin @(negedge clk); k++; end while (!scl_rise);
    check_eq("R5 current low unchanged", k, 60);
    measure_from_rise(hi, lo, samp, nsamp);
    check_eq("R5 next period high", hi, half_len(7, 0, 0));
    check_eq("R5 next period low", lo, half_len(7, 0, 0));

    load_cfg(5, 0, 0);
    wait_rise();
    wait_rise();

    // R8: stretch outlasting the low phase
    wait_fall();
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 10) stretch = 1'b1;
      if (k == 100) stretch = 1'b0;
    end while (!scl_rise);
    check_eq("R8 rise after release", k, 101);
    k = 0;
    do begin @(negedge clk); k++; end while (!scl_fall);
    check_eq("R8 full high after release", k, 60);

    // R8: stretch released before the low phase ends
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 10) stretch = 1'b1;
      if (k == 30) stretch = 1'b0;
    end while (!scl_rise);
    check_eq("R8 short stretch no effect", k, 60);

    // R8: stretch during high has no effect
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 5) stretch = 1'b1;
      if (k == 50) stretch = 1'b0;
    end while (!scl_fall);
    check_eq("R8 stretch in high no effect", k, 60);
    stretch = 1'b0;

    // R9: disable, and R5: load while disabled
    @(negedge clk);
    en = 1'b0;
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!scl_o || scl_rise || scl_fall || sample_tick) bad++;
      if (i == 20) begin cfg_thp = 8'd6; cfg_div = 7'd0; cfg_load = 1'b1; end
      if (i == 21) cfg_load = 1'b0;
    end
    check_eq("R9 idle quiet cycles", bad, 0);
    en = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!scl_fall);
    check_eq("R5 R9 disabled load applies on enable", k, half_len(6, 0, 0) + 1);

    // Random settings
    void'($urandom(32'd4711));
    for (int r = 0; r < 6; r++) begin
      int thp, m, n;
      thp = $urandom_range(9, 5);
      m   = $urandom_range(3, 0);
      n   = $urandom_range(1, 0);
      load_cfg(thp, m, n);
      wait_rise();
      period_check("R2 random", half_len(thp, m, n));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule